// File: doc/BRIEF.md
# Reference-Counted Descriptor Pool Manager

This block owns a pool of buffer descriptors and hands them out and takes them back. Each descriptor has eight 32-bit words. The block models the fields it manages: the buffer link in word 0, and word 2, which holds the packet size, the home free-list number and an 8-bit reference count. The descriptors are grouped into several free lists. Each list is a singly linked LIFO chain threaded through word 0 of its members. A consumer asks for a buffer from a chosen list and gets the head index back in the same cycle. The allocated descriptor starts with a reference count of one.

A replication stage that makes extra copies of a packet raises the count of the shared descriptor. Each consumer that finishes with it lowers the count. The descriptor goes back to its home list only when the last reference is dropped, so several copies can share one data buffer safely. A raise and a drop that target the same descriptor in one cycle are folded into one net update. A drop on a descriptor that holds no reference sets a sticky fault flag and changes nothing else. A read port shows word 0 and word 2 of any descriptor.

Top module: `fl_mgr`

## Requirements
- R1: After reset, descriptor i has reference count 0, packet size 0 and home list i mod NUM_LISTS. Each list is chained in ascending index order through word 0, starting at descriptor number equal to the list number. The last member of a list holds the null link 32'hFFFF_FFFF.
- R2: With alloc_req_i high, alloc_vld_o and alloc_idx_o show the current head of list alloc_list_i in the same cycle, before any clock edge. alloc_vld_o is 0 when that list is empty, when the list number is not below NUM_LISTS, or when there is no request.
- R3: An allocation sets the descriptor's count to 1, stores alloc_size_i as its packet size and sets its word 0 to the null link. Word 2 is read as size in bits 31:16, home list in bits 15:12, zeros in bits 11:8 and count in bits 7:0.
- R4: An increment request adds one to the count of inc_idx_i.
- R5: A decrement request subtracts one from the count of dec_idx_i. When the count reaches zero, the descriptor becomes the new head of its home list. Its word 0 then points to the previous head, or holds the null link if the list was empty.
- R6: An increment and a decrement to the same descriptor in the same cycle leave its count unchanged. They never return it to a list and never raise the fault flag.
- R7: When an allocation and a release hit the same list in one cycle, the allocation gets the old head. The released descriptor becomes the new head and links to the old head's successor. If the list was empty, the allocation is not valid.
- R8: A decrement that is not paired with an increment, on a descriptor whose count is 0, sets err_o. err_o stays set until reset. The counts and lists are left unchanged.
- R9: The home list of a descriptor never changes through allocation and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocate request |
| alloc_list_i | input | LW | List to allocate from |
| alloc_size_i | input | 16 | Packet size written on allocation |
| alloc_vld_o | output | 1 | Allocation granted this cycle |
| alloc_idx_o | output | AW | Granted descriptor index |
| inc_req_i | input | 1 | Add one reference |
| inc_idx_i | input | AW | Descriptor to increment |
| dec_req_i | input | 1 | Drop one reference |
| dec_idx_i | input | AW | Descriptor to decrement |
| rd_idx_i | input | AW | Descriptor to read |
| rd_link_o | output | 32 | Word 0 of the read descriptor |
| rd_word2_o | output | 32 | Word 2 of the read descriptor |
| err_o | output | 1 | Sticky fault: decrement on zero count |

## Verification
The bench builds the block with NUM_DESC=8 and NUM_LISTS=2. With these values each list holds only four members, so a short sequence of allocations empties a list. This brings two cases within a few cycles: allocating from an empty list, and a release that lands on an empty list in the same cycle as an allocation. With two lists, releases can be checked for returning to the correct home list, and the interleaved initial chains can be checked. The 3-bit index also keeps every reachable descriptor easy to read back through the read port.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam logic [31:0] NULL_LINK = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [31:0] link;
    logic [15:0] size;
    logic [3:0]  list_id;
    logic [7:0]  cnt;
  } desc_t;
endpackage

// File: rtl/fl_cnt_cell.sv
module fl_cnt_cell (
  input  logic [7:0] cnt_i,
  input  logic       inc_i,
  input  logic       dec_i,
  input  logic       alloc_i,
  output logic [7:0] cnt_o,
  output logic       free_o,
  output logic       err_o
);
  logic merged;
  assign merged = inc_i & dec_i;

  always_comb begin
    cnt_o  = cnt_i;
    free_o = 1'b0;
    err_o  = dec_i & ~inc_i & (cnt_i == 8'd0);
    if (alloc_i) begin
      cnt_o = 8'd1;
    end else if (merged) begin
      cnt_o = cnt_i;
    end else if (inc_i) begin
      cnt_o = cnt_i + 8'd1;
    end else if (dec_i && cnt_i != 8'd0) begin
      cnt_o  = cnt_i - 8'd1;
      free_o = (cnt_i == 8'd1);
    end
  end
endmodule

// File: rtl/fl_heads.sv
module fl_heads #(
  parameter int NUM_DESC  = 16,
  parameter int NUM_LISTS = 2,
  localparam int AW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int LW = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [LW-1:0] pop_list_i,
  input  logic [31:0]   pop_link_i,
  input  logic          push_i,
  input  logic [LW-1:0] push_list_i,
  input  logic [AW-1:0] push_idx_i,
  output logic [AW-1:0] head_idx_o [NUM_LISTS],
  output logic          head_vld_o [NUM_LISTS],
  output logic [31:0]   push_link_o
);
  import fl_pkg::*;

  logic [AW-1:0] ap_idx [NUM_LISTS];
  logic          ap_vld [NUM_LISTS];
  logic [LW-1:0] push_sel;

  for (genvar l = 0; l < NUM_LISTS; l++) begin : g_list
    logic pop_l, push_l;
    assign pop_l  = pop_i  && (pop_list_i  == LW'(l));
    assign push_l = push_i && (push_list_i == LW'(l));

    // head after this cycle's pop, before any push
    always_comb begin
      ap_idx[l] = head_idx_o[l];
      ap_vld[l] = head_vld_o[l];
      if (pop_l) begin
        ap_vld[l] = (pop_link_i != NULL_LINK);
        ap_idx[l] = pop_link_i[AW-1:0];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        head_idx_o[l] <= AW'(l);
        head_vld_o[l] <= (l < NUM_DESC);
      end else if (push_l) begin
        head_idx_o[l] <= push_idx_i;
        head_vld_o[l] <= 1'b1;
      end else begin
        head_idx_o[l] <= ap_idx[l];
        head_vld_o[l] <= ap_vld[l];
      end
    end
  end

  assign push_sel    = (32'(push_list_i) < NUM_LISTS) ? push_list_i : '0;
  assign push_link_o = ap_vld[push_sel] ? 32'(ap_idx[push_sel]) : NULL_LINK;
endmodule

// File: rtl/fl_mgr.sv
module fl_mgr #(
  parameter int NUM_DESC  = 16,
  parameter int NUM_LISTS = 2,
  localparam int AW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int LW = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_req_i,
  input  logic [LW-1:0] alloc_list_i,
  input  logic [15:0]   alloc_size_i,
  output logic          alloc_vld_o,
  output logic [AW-1:0] alloc_idx_o,
  input  logic          inc_req_i,
  input  logic [AW-1:0] inc_idx_i,
  input  logic          dec_req_i,
  input  logic [AW-1:0] dec_idx_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [31:0]   rd_link_o,
  output logic [31:0]   rd_word2_o,
  output logic          err_o
);
  import fl_pkg::*;

  desc_t         desc_q [NUM_DESC];
  logic [AW-1:0] head_idx [NUM_LISTS];
  logic          head_vld [NUM_LISTS];
  logic [7:0]    cnt_n [NUM_DESC];
  logic [NUM_DESC-1:0] free_v, err_v, alloc_hit;
  logic          list_ok;
  logic [LW-1:0] list_sel;
  logic [31:0]   push_link;
  logic [LW-1:0] push_list;
  desc_t         dec_desc, rd_desc;

  assign list_ok     = (32'(alloc_list_i) < NUM_LISTS);
  assign list_sel    = list_ok ? alloc_list_i : '0;
  assign alloc_vld_o = alloc_req_i & list_ok & head_vld[list_sel];
  assign alloc_idx_o = head_idx[list_sel];

  assign dec_desc  = desc_q[dec_idx_i];
  assign push_list = dec_desc.list_id[LW-1:0];

  fl_heads #(.NUM_DESC(NUM_DESC), .NUM_LISTS(NUM_LISTS)) u_heads (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (alloc_vld_o),
    .pop_list_i  (list_sel),
    .pop_link_i  (desc_q[alloc_idx_o].link),
    .push_i      (|free_v),
    .push_list_i (push_list),
    .push_idx_i  (dec_idx_i),
    .head_idx_o  (head_idx),
    .head_vld_o  (head_vld),
    .push_link_o (push_link)
  );

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    assign alloc_hit[i] = alloc_vld_o && (alloc_idx_o == AW'(i));

    fl_cnt_cell u_cell (
      .cnt_i   (desc_q[i].cnt),
      .inc_i   (inc_req_i && (inc_idx_i == AW'(i))),
      .dec_i   (dec_req_i && (dec_idx_i == AW'(i))),
      .alloc_i (alloc_hit[i]),
      .cnt_o   (cnt_n[i]),
      .free_o  (free_v[i]),
      .err_o   (err_v[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        desc_q[i].link    <= (i + NUM_LISTS < NUM_DESC) ? 32'(i + NUM_LISTS) : NULL_LINK;
        desc_q[i].size    <= '0;
        desc_q[i].list_id <= 4'(i % NUM_LISTS);
        desc_q[i].cnt     <= '0;
      end else begin
        desc_q[i].cnt <= cnt_n[i];
        if (alloc_hit[i]) begin
          desc_q[i].link <= NULL_LINK;
          desc_q[i].size <= alloc_size_i;
        end else if (free_v[i]) begin
          desc_q[i].link <= push_link;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else if (|err_v) err_o <= 1'b1;
  end

  assign rd_desc    = desc_q[rd_idx_i];
  assign rd_link_o  = rd_desc.link;
  assign rd_word2_o = {rd_desc.size, rd_desc.list_id, 4'h0, rd_desc.cnt};
endmodule

// File: rtl/fl_mgr_chk.sv
module fl_mgr_chk #(
  parameter int NUM_DESC = 16,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          alloc_req_i,
  input logic          alloc_vld_o,
  input logic [AW-1:0] alloc_idx_o,
  input logic          dec_req_i,
  input logic [31:0]   rd_word2_o,
  input logic          err_o
);
  p_grant_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_vld_o |-> alloc_req_i);

  p_grant_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_vld_o |-> (32'(alloc_idx_o) < NUM_DESC));

  // an allocated descriptor cannot be freed in its own cycle, so no back-to-back repeat
  p_no_double_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && alloc_vld_o && $past(alloc_vld_o)) |-> (alloc_idx_o != $past(alloc_idx_o)));

  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word2_o[11:8] == 4'h0);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $rose(err_o)) |-> $past(dec_req_i));
endmodule

bind fl_mgr fl_mgr_chk #(.NUM_DESC(NUM_DESC), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alloc_req_i (alloc_req_i),
  .alloc_vld_o (alloc_vld_o),
  .alloc_idx_o (alloc_idx_o),
  .dec_req_i   (dec_req_i),
  .rd_word2_o  (rd_word2_o),
  .err_o       (err_o)
);

// File: tb/sim_fl_mgr.sv
module sim_fl_mgr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_req_i = 1'b0;
  logic [0:0]  alloc_list_i = '0;
  logic [15:0] alloc_size_i = 16'h0100;
  logic        alloc_vld_o;
  logic [2:0]  alloc_idx_o;
  logic        inc_req_i = 1'b0;
  logic [2:0]  inc_idx_i = '0;
  logic        dec_req_i = 1'b0;
  logic [2:0]  dec_idx_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [31:0] rd_link_o, rd_word2_o;
  logic        err_o;
  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  fl_mgr #(.NUM_DESC(8), .NUM_LISTS(2)) u0 (.*);

  // {alloc_req, list, inc, inc_idx, dec, dec_idx, exp_vld, exp_idx}
  localparam logic [13:0] VEC [15] = '{
    14'b1_0_0_000_0_000_1_000,
    14'b1_1_0_000_0_000_1_001,
    14'b1_0_1_000_0_000_1_010,
    14'b0_0_0_000_1_000_0_000,
    14'b1_1_0_000_1_000_1_011,
    14'b1_0_0_000_0_000_1_000,
    14'b1_0_1_001_1_001_1_100,
    14'b1_1_0_000_1_001_1_101,
    14'b1_1_0_000_0_000_1_001,
    14'b1_1_0_000_0_000_1_111,
    14'b1_1_0_000_0_000_0_000,
    14'b1_1_0_000_1_011_0_000,
    14'b1_1_0_000_0_000_1_011,
    14'b1_0_0_000_0_000_1_110,
    14'b1_0_0_000_1_010_0_000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req_i = 1'b0; inc_req_i = 1'b0; dec_req_i = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [2:0] idx);
    rd_idx_i = idx;
    #1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: initial chains and fields
    rd(3'd0); chk("R1 link0", rd_link_o, 32'd2);  chk("R1 word2_0", rd_word2_o, 32'h0000_0000);
    rd(3'd5); chk("R1 link5", rd_link_o, 32'd7);  chk("R1 word2_5", rd_word2_o, 32'h0000_1000);
    rd(3'd7); chk("R1 link7", rd_link_o, 32'hFFFF_FFFF);
    chk("R1 err", 32'(err_o), 32'd0);
    chk("R2 no req", 32'(alloc_vld_o), 32'd0);

    // table walk covers R2, R4, R5, R6, R7 ordering
    foreach (VEC[k]) begin
      alloc_req_i  = VEC[k][13];
      alloc_list_i = VEC[k][12];
      inc_req_i    = VEC[k][11];
      inc_idx_i    = VEC[k][10:8];
      dec_req_i    = VEC[k][7];
      dec_idx_i    = VEC[k][6:4];
      #1;
      chk($sformatf("R2 vld step %0d", k), 32'(alloc_vld_o), 32'(VEC[k][3]));
      if (VEC[k][3]) chk($sformatf("R7 idx step %0d", k), 32'(alloc_idx_o), 32'(VEC[k][2:0]));
      tick();
    end
    idle();
    #1;
    chk("R8 no err after table", 32'(err_o), 32'd0);

    // R3: allocated descriptor fields
    rd(3'd3); chk("R3 word2_3", rd_word2_o, 32'h0100_1001); chk("R3 link3", rd_link_o, 32'hFFFF_FFFF);
    rd(3'd2); chk("R5 word2_2 freed", rd_word2_o, 32'h0100_0000); chk("R7 link2", rd_link_o, 32'hFFFF_FFFF);
    rd(3'd0); chk("R4 cnt0", 32'(rd_word2_o[7:0]), 32'd1);

    // R4: increments
    inc_req_i = 1'b1; inc_idx_i = 3'd3; tick();
    tick(); idle();
    rd(3'd3); chk("R4 cnt3", 32'(rd_word2_o[7:0]), 32'd3);
    dec_req_i = 1'b1; dec_idx_i = 3'd3; tick(); tick(); idle();
    rd(3'd3); chk("R5 cnt3 down", 32'(rd_word2_o[7:0]), 32'd1);

    // R5: release onto empty list then push
    dec_req_i = 1'b1; dec_idx_i = 3'd3; tick();
    dec_idx_i = 3'd5; tick(); idle();
    rd(3'd3); chk("R5 cnt3 zero", rd_word2_o, 32'h0100_1000);
    rd(3'd5); chk("R5 link5", rd_link_o, 32'd3); chk("R9 list5", 32'(rd_word2_o[15:12]), 32'd1);
    alloc_req_i = 1'b1; alloc_list_i = 1'b1; #1;
    chk("R5 lifo head", 32'(alloc_idx_o), 32'd5);
    idle();

    // R6: merged on zero count
    inc_req_i = 1'b1; inc_idx_i = 3'd2; dec_req_i = 1'b1; dec_idx_i = 3'd2; tick(); idle();
    #1;
    chk("R6 err", 32'(err_o), 32'd0);
    rd(3'd2); chk("R6 cnt2", 32'(rd_word2_o[7:0]), 32'd0);

    // R8: decrement on zero
    dec_req_i = 1'b1; dec_idx_i = 3'd2; tick(); idle();
    #1;
    chk("R8 err set", 32'(err_o), 32'd1);
    rd(3'd2); chk("R8 cnt2", 32'(rd_word2_o[7:0]), 32'd0);
    alloc_req_i = 1'b1; alloc_list_i = 1'b0; #1;
    chk("R8 list kept vld", 32'(alloc_vld_o), 32'd1);
    chk("R8 list kept idx", 32'(alloc_idx_o), 32'd2);
    tick(); #1;
    chk("R8 list now empty", 32'(alloc_vld_o), 32'd0);
    idle();
    tick(); tick(); #1;
    chk("R8 err sticky", 32'(err_o), 32'd1);
    rd(3'd2); chk("R9 list2", 32'(rd_word2_o[15:12]), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule